// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block produces the column address for every beat of a read or write burst in a synchronous DRAM controller. A start strobe loads the starting column together with a 3-bit length code and an order select. From the next cycle on, the block presents beat 0 on its column output. Each advance strobe moves it to the following beat.

Fixed-length bursts stay inside the aligned window that the length defines. In sequential order the low bits count up and wrap inside that window. In interleaved order the low bits of the start column are XORed with the beat number. A full-page burst steps through the whole 8-bit column space, wraps around, and continues until it is stopped. Interleaved order cannot be combined with full page, so that pairing is flagged and run as an interleaved burst of eight.

A stop strobe ends a burst on any cycle. A new start strobe restarts the sequencer at a new column on any cycle, even in the middle of a burst. The last-beat output marks the final beat of a fixed-length burst. The busy output shows that a burst is in progress.

Top module: `burst_col_seq`

## Requirements
- R1: While rst_ni is low and after its release, busy_o, last_o, illegal_o and col_o are all 0.
- R2: A cycle with start_i high gives busy_o=1 and col_o equal to that cycle's start_col_i in the next cycle. start_i wins over stop_i and advance_i in the same cycle and restarts a burst that is in progress.
- R3: The burst length is taken from len_code_i at start: 3'b000=1, 3'b001=2, 3'b010=4, 3'b011=8, 3'b111=full page. The codes 3'b100, 3'b101 and 3'b110 give length 1.
- R4: With interleave_i=0 and a fixed length L, beat n presents a column whose bits above log2(L) equal those of the start column. Its low log2(L) bits are (start + n) mod L.
- R5: With interleave_i=1 and a fixed length L, beat n presents the start column with its low log2(L) bits XORed with n.
- R6: In full page, beat n presents (start + n) mod 256 and last_o is never 1.
- R7: The pair interleave_i=1 and len_code_i=3'b111 at start sets illegal_o=1 from the next cycle, and the burst runs as an interleaved burst of 8. illegal_o follows each new start and is 0 after a legal start.
- R8: last_o is 1 exactly while the final beat of a fixed-length burst is presented. An advance on that beat drops busy_o in the next cycle, and col_o keeps the final column.
- R9: During a burst, a cycle without advance_i leaves col_o and last_o unchanged.
- R10: stop_i without start_i drops busy_o and last_o in the next cycle and holds col_o. advance_i while idle has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load the start column and configuration, begin at beat 0 |
| start_col_i | input | 8 | Start column |
| len_code_i | input | 3 | Burst length code |
| interleave_i | input | 1 | 1 = interleaved (XOR) order, 0 = sequential order |
| advance_i | input | 1 | Step to the next beat |
| stop_i | input | 1 | End the burst in progress |
| col_o | output | 8 | Column address of the current beat |
| last_o | output | 1 | Final beat of a fixed-length burst |
| busy_o | output | 1 | Burst in progress |
| illegal_o | output | 1 | Last start asked for interleaved full page |

## Verification
The function pairs that can fall in the same cycle are listed below.
- A restart can arrive together with an advance or a stop during a running burst.
- A stop can coincide with an advance on the final beat.
- An advance on the final beat can fall in the same cycle as a new start.

Directed sequences place a start strobe on the same cycle as stop and advance in mid-burst and on the last beat. A random phase then mixes all strobes at once. A behavioural model of column, beat and busy state judges each case by comparing all four outputs on every clock. The model resolves these collisions by the stated priority: start first, then stop, then advance.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int unsigned LEN_CODE_W = 3;

  typedef enum logic [1:0] {
    ORD_SEQ  = 2'd0,
    ORD_XOR  = 2'd1,
    ORD_PAGE = 2'd2
  } order_e;

  typedef struct packed {
    logic [LEN_CODE_W-1:0] code;
    logic                  interleave;
  } len_req_t;
endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
  import burst_seq_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  len_req_t   req_i,
  output order_e     order_o,
  output logic [COL_W-1:0] mask_o,
  output logic       illegal_o
);
  localparam logic [COL_W-1:0] MASK_2 = COL_W'(1);
  localparam logic [COL_W-1:0] MASK_4 = COL_W'(3);
  localparam logic [COL_W-1:0] MASK_8 = COL_W'(7);

  always_comb begin
    order_o   = req_i.interleave ? ORD_XOR : ORD_SEQ;
    mask_o    = '0;
    illegal_o = 1'b0;
    unique case (req_i.code)
      3'b000: mask_o = '0;
      3'b001: mask_o = MASK_2;
      3'b010: mask_o = MASK_4;
      3'b011: mask_o = MASK_8;
      3'b111: begin
        if (req_i.interleave) begin
          // unsupported pairing: flag it and run as eight beats
          mask_o    = MASK_8;
          illegal_o = 1'b1;
        end else begin
          mask_o  = '1;
          order_o = ORD_PAGE;
        end
      end
      default: mask_o = '0;
    endcase
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_seq_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  order_e           order_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] sum;

  assign sum = base_i + beat_i;

  always_comb begin
    unique case (order_i)
      ORD_PAGE: col_o = sum;
      ORD_XOR:  col_o = base_i ^ (beat_i & mask_i);
      default:  col_o = (base_i & ~mask_i) | (sum & mask_i);
    endcase
  end
endmodule

// File: rtl/burst_beat_ctrl.sv
module burst_beat_ctrl #(
  parameter int unsigned COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             advance_i,
  input  logic             stop_i,
  input  logic             page_i,
  input  logic [COL_W-1:0] mask_i,
  output logic [COL_W-1:0] beat_o,
  output logic             last_o,
  output logic             busy_o
);
  logic [COL_W-1:0] beat_q;
  logic             busy_q;
  logic             last;

  assign last   = busy_q && !page_i && (beat_q == mask_i);
  assign beat_o = beat_q;
  assign last_o = last;
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beat_q <= '0;
      busy_q <= 1'b0;
    end else if (start_i) begin
      beat_q <= '0;
      busy_q <= 1'b1;
    end else if (stop_i) begin
      busy_q <= 1'b0;
    end else if (busy_q && advance_i) begin
      if (last) busy_q <= 1'b0;
      else      beat_q <= beat_q + 1'b1;
    end
  end

  // R8: advancing off the final beat ends the burst
  a_r8_end_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last && advance_i && !start_i |=> !busy_o);

  // R10: stop ends the burst
  a_r10_stop_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && !start_i |=> !busy_o && !last_o);

  // R6: full page never raises last
  a_r6_page_no_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    page_i |-> !last_o);

  // R9: stall holds the beat
  a_r9_stall_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !advance_i && !start_i && !stop_i |=> $stable(beat_o) && $stable(last_o));
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_seq_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       len_code_i,
  input  logic             interleave_i,
  input  logic             advance_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             last_o,
  output logic             busy_o,
  output logic             illegal_o
);
  len_req_t         req;
  order_e           order_d, order_q;
  logic [COL_W-1:0] mask_d, mask_q;
  logic             illegal_d, illegal_q;
  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] beat;

  assign req.code       = len_code_i;
  assign req.interleave = interleave_i;

  burst_len_decode #(.COL_W(COL_W)) i_decode (
    .req_i     (req),
    .order_o   (order_d),
    .mask_o    (mask_d),
    .illegal_o (illegal_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q    <= '0;
      order_q   <= ORD_SEQ;
      mask_q    <= '0;
      illegal_q <= 1'b0;
    end else if (start_i) begin
      base_q    <= start_col_i;
      order_q   <= order_d;
      mask_q    <= mask_d;
      illegal_q <= illegal_d;
    end
  end

  burst_beat_ctrl #(.COL_W(COL_W)) i_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .advance_i (advance_i),
    .stop_i    (stop_i),
    .page_i    (order_q == ORD_PAGE),
    .mask_i    (mask_q),
    .beat_o    (beat),
    .last_o    (last_o),
    .busy_o    (busy_o)
  );

  burst_col_gen #(.COL_W(COL_W)) i_colgen (
    .base_i  (base_q),
    .beat_i  (beat),
    .mask_i  (mask_q),
    .order_i (order_q),
    .col_o   (col_o)
  );

  assign illegal_o = illegal_q;

  // R2: start presents the start column as beat 0
  a_r2_start_col: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o && col_o == $past(start_col_i));

  // R4/R5: fixed-length bursts stay inside the aligned window
  a_r4_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && order_q != ORD_PAGE |-> (col_o & ~mask_q) == (base_q & ~mask_q));

  // R7: interleaved full page is flagged
  a_r7_illegal_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> illegal_o == ($past(interleave_i) && $past(len_code_i) == 3'b111));

  // R10: idle column holds
  a_r10_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !start_i |=> $stable(col_o) && !last_o);
endmodule

// File: tb/test_burst_col_seq.sv
module test_burst_col_seq;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start = 1'b0;
  logic [7:0] start_col = 8'h00;
  logic [2:0] len_code = 3'b000;
  logic       interleave = 1'b0;
  logic       advance = 1'b0;
  logic       stop = 1'b0;
  logic [7:0] col;
  logic       last, busy, illegal;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;
  string req = "R1";

  // model state
  int  m_busy = 0, m_base = 0, m_n = 0, m_len = 1, m_il = 0, m_ill = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_col_seq i_burst_col_seq (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .start_col_i(start_col),
    .len_code_i(len_code), .interleave_i(interleave), .advance_i(advance),
    .stop_i(stop), .col_o(col), .last_o(last), .busy_o(busy), .illegal_o(illegal)
  );

  function automatic int exp_col();
    if (m_len == 0) return (m_base + m_n) % 256;
    if (m_il != 0)  return m_base ^ m_n;
    return (m_base - (m_base % m_len)) + ((m_base % m_len) + m_n) % m_len;
  endfunction

  function automatic int exp_last();
    return (m_busy != 0 && m_len != 0 && m_n == m_len - 1) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    if (rst_ni) begin
      if (start) begin
        m_base = start_col; m_n = 0; m_busy = 1; m_il = interleave;
        m_ill = (interleave && len_code == 3'b111) ? 1 : 0;
        case (len_code)
          3'b000: m_len = 1;
          3'b001: m_len = 2;
          3'b010: m_len = 4;
          3'b011: m_len = 8;
          3'b111: m_len = interleave ? 8 : 0;
          default: m_len = 1;
        endcase
      end else if (stop) begin
        m_busy = 0;
      end else if (advance && m_busy != 0) begin
        if (exp_last() != 0) m_busy = 0;
        else m_n = (m_n + 1) % 256;
      end
    end
  end

  task automatic compare();
    compared++;
    if (col !== 8'(exp_col()) || last !== 1'(exp_last()) ||
        busy !== 1'(m_busy) || illegal !== 1'(m_ill)) begin
      mismatched++;
      $display("FAIL %s: col=%0h last=%0b busy=%0b ill=%0b expected col=%0h last=%0b busy=%0b ill=%0b",
               req, col, last, busy, illegal, exp_col(), exp_last(), m_busy, m_ill);
    end
  endtask

  always @(negedge clk) if (rst_ni && !done) compare();

  task automatic drive(input logic st, input logic [7:0] c, input logic [2:0] code,
                       input logic il, input logic adv, input logic stp);
    @(negedge clk);
    #1;
    start = st; start_col = c; len_code = code; interleave = il;
    advance = adv; stop = stp;
  endtask

  task automatic run_burst(input logic [7:0] c, input logic [2:0] code,
                           input logic il, input int beats);
    drive(1'b1, c, code, il, 1'b0, 1'b0);
    for (int i = 0; i < beats; i++) drive(1'b0, 8'h00, 3'b000, 1'b0, 1'b1, 1'b0);
  endtask

  initial begin
    #3;
    req = "R1";
    compared++;
    if (col !== 8'h00 || last !== 1'b0 || busy !== 1'b0 || illegal !== 1'b0) begin
      mismatched++;
      $display("FAIL R1: col=%0h last=%0b busy=%0b ill=%0b expected all zero",
               col, last, busy, illegal);
    end
    @(negedge clk);
    @(negedge clk);
    #1 rst_ni = 1'b1;
    drive(1'b0, 8'h00, 3'b000, 1'b0, 1'b0, 1'b0);

    req = "R2";
    run_burst(8'h35, 3'b010, 1'b0, 1);
    drive(1'b1, 8'h9A, 3'b011, 1'b0, 1'b1, 1'b1);   // start with stop and advance
    drive(1'b0, 8'h00, 3'b000, 1'b0, 1'b1, 1'b0);
    drive(1'b1, 8'h41, 3'b001, 1'b1, 1'b1, 1'b0);   // restart mid-burst

    req = "R3";
    for (int k = 0; k < 8; k++) run_burst(8'h13, 3'(k), 1'b0, 10);
    drive(1'b0, 8'h00, 3'b000, 1'b0, 1'b0, 1'b1);

    req = "R4";
    run_burst(8'h2D, 3'b011, 1'b0, 9);
    run_burst(8'h7B, 3'b010, 1'b0, 5);

    req = "R5";
    run_burst(8'h1E, 3'b010, 1'b1, 5);
    run_burst(8'hC5, 3'b011, 1'b1, 9);

    req = "R6";
    run_burst(8'hFC, 3'b111, 1'b0, 6);
    drive(1'b0, 8'h00, 3'b000, 1'b0, 1'b0, 1'b1);

    req = "R7";
    run_burst(8'h45, 3'b111, 1'b1, 9);
    run_burst(8'h10, 3'b001, 1'b1, 2);

    req = "R8";
    run_burst(8'h06, 3'b001, 1'b0, 1);
    drive(1'b1, 8'h50, 3'b000, 1'b0, 1'b1, 1'b0);   // start on last-beat advance
    drive(1'b0, 8'h00, 3'b000, 1'b0, 1'b1, 1'b1);   // stop with advance on last beat

    req = "R9";
    drive(1'b1, 8'h61, 3'b011, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 16; i++) drive(1'b0, 8'h00, 3'b000, 1'b0, 1'(i % 3 == 0), 1'b0);

    req = "R10";
    run_burst(8'h88, 3'b011, 1'b1, 3);
    drive(1'b0, 8'h00, 3'b000, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 4; i++) drive(1'b0, 8'hFF, 3'b111, 1'b1, 1'b1, 1'b0);

    req = "R2 R3 R8 R9 random";
    for (int i = 0; i < 400; i++)
      drive(1'(($urandom % 8) == 0), 8'($urandom), 3'($urandom), 1'($urandom),
            1'(($urandom % 4) != 0), 1'(($urandom % 16) == 0));
    drive(1'b0, 8'h00, 3'b000, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      mismatched++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule